// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register Window

This block is the software-facing register file of an interrupt router. A small memory-mapped slave exposes three locations: a selector that holds an 8-bit register index, a 32-bit data window through which the selected register is read or written, and an end-of-interrupt location. Through the window, software reaches an identification register, a read-only version word, an arbitration word that mirrors the identification value, and both 32-bit halves of every 64-bit routing entry.

The block holds the routing entries and keeps them consistent on every write. The two status bits of an entry belong to the interrupt datapath: they change only through a separate status port, and bus writes never touch them. A write that leaves an entry in edge mode clears its pending-acknowledge bit. The block does not route interrupts. It raises a one-cycle service request naming the entry that software changed, and a one-cycle end-of-interrupt pulse carrying the vector that software wrote.

A controller with three named states handles each request. `ST_IDLE` accepts a request (`req_ready` high) and moves to `ST_EXEC` on `req_valid`. `ST_EXEC` decodes the captured request and performs it, then always moves to `ST_RESP`. `ST_RESP` presents the response for one cycle and always returns to `ST_IDLE`.

Top module: `irq_index_window`

## Requirements
- R1: After reset the selector reads 0, the identification field reads 0, and every entry reads low half 0x0001_0000 (only the mask bit, bit 16, set) and high half 0.
- R2: `req_ready` is high only in `ST_IDLE`. A request accepted at a clock edge gives `rsp_valid` high for exactly one cycle after the second following edge. A write's response carries data 0.
- R3: A write of any size to offset 0x00 loads the selector from `req_wdata[7:0]`. A read of any size returns the selector in bits 7:0.
- R4: Window (0x10) and end-of-interrupt (0x40) accesses take effect only when `req_size` equals 4. With any other size, a read returns 0 and a write changes nothing and raises no pulse.
- R5: With selector 0, a window write stores `req_wdata[27:24]` as the identification value. Selectors 0 and 2 both read that value in bits 27:24, with every other bit 0.
- R6: Selector 1 reads the version code in bits 7:0 and (entry count − 1) in bits 23:16. Window writes to selectors 1 and 2 change nothing.
- R7: A selector s ≥ 0x10 addresses entry (s − 0x10) >> 1. An odd s selects bits 63:32 and an even s selects bits 31:0. Selectors 3–0x0F, and selectors beyond the last entry, read 0; writes to them change nothing and raise no service request.
- R8: Bit 12 (delivery status) and bit 14 (pending acknowledge) of an entry are set only through `stat_valid`/`stat_idx`/`stat_dlv`/`stat_rirr`, taking effect at the next clock edge. Window writes keep both bits at their previous values.
- R9: After any window write to an entry, bit 14 reads 0 if bit 15 (trigger mode, 0 = edge, 1 = level) of the resulting entry is 0.
- R10: Every window write to a valid entry raises `svc_valid` for one cycle, together with `rsp_valid`, with `svc_idx` set to the entry number.
- R11: A 4-byte write to 0x40 raises `eoi_valid` for one cycle, together with `rsp_valid`, with `eoi_vector` = `req_wdata[7:0]`, but only when the version parameter is 0x20. When the version is 0x11 the write has no effect. Any version value other than 0x20 is treated as 0x11.
- R12: Offsets other than 0x00, 0x10 and 0x40 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Low address bits of the access |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| stat_valid | input | 1 | Datapath status update strobe |
| stat_idx | input | IDX_W (5) | Entry whose status bits are updated |
| stat_dlv | input | 1 | New delivery-status bit |
| stat_rirr | input | 1 | New pending-acknowledge bit |
| svc_valid | output | 1 | An entry was rewritten by software |
| svc_idx | output | IDX_W (5) | Number of the rewritten entry |
| eoi_valid | output | 1 | End-of-interrupt written |
| eoi_vector | output | 8 | Vector of the end-of-interrupt |

## Verification
Every response and every service or end-of-interrupt pulse appears in the cycle after the second clock edge following acceptance. The bench therefore samples them on the falling edge after that second edge. It also checks on the falling edge before that edge that `rsp_valid` is still low. Register and table contents change at the execute edge, so each readback is a separate, later transaction. Status-port updates take effect one edge after the strobe and are read back only after that edge.

// File: rtl/irw_pkg.sv
package irw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_RESP
    } irw_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SEL,
        OP_WIN,
        OP_EOI
    } irw_op_e;

    typedef enum logic [2:0] {
        WS_NONE,
        WS_ID,
        WS_VER,
        WS_ARB,
        WS_ENT
    } irw_win_e;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [2:0]  size;
        logic [31:0] wdata;
    } irw_req_t;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_ENT_BASE = 8'h10;

    localparam logic [2:0] FULL_SIZE = 3'd4;

    localparam int BIT_DLV  = 12;
    localparam int BIT_RIRR = 14;
    localparam int BIT_TRIG = 15;
    localparam int BIT_MASK = 16;

    localparam int ID_LSB  = 24;
    localparam int CNT_LSB = 16;

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic [7:0]       cap_addr,
    input  logic [2:0]       cap_size,
    input  logic [7:0]       sel_q,
    output irw_op_e          op,
    output irw_win_e         win,
    output logic [IDX_W-1:0] ent_num,
    output logic             ent_hi
);

    logic [7:0] rel;
    logic       ent_ok;
    logic       full;

    always_comb begin
        rel     = sel_q - SEL_ENT_BASE;
        ent_ok  = (sel_q >= SEL_ENT_BASE) && (int'(rel[7:1]) < NUM_PINS);
        ent_num = ent_ok ? IDX_W'(rel[7:1]) : '0;
        ent_hi  = sel_q[0];
        full    = (cap_size == FULL_SIZE);

        if (sel_q == SEL_ID)
            win = WS_ID;
        else if (sel_q == SEL_VER)
            win = WS_VER;
        else if (sel_q == SEL_ARB)
            win = WS_ARB;
        else if (ent_ok)
            win = WS_ENT;
        else
            win = WS_NONE;

        if (cap_addr == OFF_SEL)
            op = OP_SEL;
        else if (cap_addr == OFF_WIN && full)
            op = OP_WIN;
        else if (cap_addr == OFF_EOI && full)
            op = OP_EOI;
        else
            op = OP_NONE;
    end

endmodule

// File: rtl/irw_table.sv
module irw_table
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_num,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic             stat_valid,
    input  logic [IDX_W-1:0] stat_idx,
    input  logic             stat_dlv,
    input  logic             stat_rirr,
    input  logic [IDX_W-1:0] rd_num,
    input  logic             rd_hi,
    output logic [31:0]      rd_data
);

    localparam logic [63:0] RESET_WORD = 64'(1) << BIT_MASK;

    logic [NUM_PINS-1:0][63:0] ent_flat;
    logic [63:0]               cur;
    logic [63:0]               merged;
    logic [63:0]               rd_word;

    always_comb begin
        cur = (int'(wr_num) < NUM_PINS) ? ent_flat[wr_num] : '0;
        merged = wr_hi ? {wr_data, cur[31:0]} : {cur[63:32], wr_data};
        merged[BIT_DLV]  = cur[BIT_DLV];
        merged[BIT_RIRR] = cur[BIT_RIRR];
        if (!merged[BIT_TRIG])
            merged[BIT_RIRR] = 1'b0;
    end

    for (genvar e = 0; e < NUM_PINS; e++) begin : g_ent
        logic [63:0] q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= RESET_WORD;
            end else begin
                if (wr_en && int'(wr_num) == e)
                    q <= merged;
                if (stat_valid && int'(stat_idx) == e) begin
                    q[BIT_DLV]  <= stat_dlv;
                    q[BIT_RIRR] <= stat_rirr;
                end
            end
        end

        assign ent_flat[e] = q;
    end

    always_comb begin
        rd_word = (int'(rd_num) < NUM_PINS) ? ent_flat[rd_num] : '0;
        rd_data = rd_hi ? rd_word[63:32] : rd_word[31:0];
    end

endmodule

// File: rtl/irw_readmux.sv
module irw_readmux
    import irw_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter int          ID_W     = 4,
    parameter logic [7:0]  VER_CODE = 8'h20
) (
    input  irw_win_e        win,
    input  logic [ID_W-1:0] id_q,
    input  logic [31:0]     tbl_data,
    output logic [31:0]     win_data
);

    localparam logic [31:0] VER_WORD =
        (32'(NUM_PINS - 1) << CNT_LSB) | 32'(VER_CODE);

    always_comb begin
        unique case (win)
            WS_ID, WS_ARB: win_data = 32'(id_q) << ID_LSB;
            WS_VER:        win_data = VER_WORD;
            WS_ENT:        win_data = tbl_data;
            default:       win_data = '0;
        endcase
    end

endmodule

// File: rtl/irw_ctrl.sv
module irw_ctrl
    import irw_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int ID_W   = 4,
    parameter bit EOI_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  irw_req_t         req_in,
    output irw_req_t         cap,
    output logic [7:0]       sel_q,
    output logic [ID_W-1:0]  id_q,
    input  irw_op_e          op,
    input  irw_win_e         win,
    input  logic [IDX_W-1:0] ent_num,
    input  logic [31:0]      win_data,
    output logic             tbl_wr_en,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic             svc_valid,
    output logic [IDX_W-1:0] svc_idx,
    output logic             eoi_valid,
    output logic [7:0]       eoi_vector
);

    irw_state_e state_q, state_d;
    logic       in_exec;
    logic       do_eoi;
    logic [31:0] rd_word;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign in_exec   = (state_q == ST_EXEC);
    assign tbl_wr_en = in_exec && cap.wr && op == OP_WIN && win == WS_ENT;
    assign do_eoi    = in_exec && cap.wr && op == OP_EOI && EOI_EN;

    always_comb begin
        unique case (op)
            OP_SEL:  rd_word = 32'(sel_q);
            OP_WIN:  rd_word = win_data;
            default: rd_word = '0;
        endcase
    end

    // Request capture and software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap   <= '0;
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid)
                cap <= req_in;
            if (in_exec && cap.wr) begin
                if (op == OP_SEL)
                    sel_q <= cap.wdata[7:0];
                if (op == OP_WIN && win == WS_ID)
                    id_q <= cap.wdata[ID_LSB +: ID_W];
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            svc_valid  <= 1'b0;
            svc_idx    <= '0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            rsp_valid <= in_exec;
            rsp_rdata <= (in_exec && !cap.wr) ? rd_word : '0;
            svc_valid <= tbl_wr_en;
            if (tbl_wr_en)
                svc_idx <= ent_num;
            eoi_valid <= do_eoi;
            if (do_eoi)
                eoi_vector <= cap.wdata[7:0];
        end
    end

endmodule

// File: rtl/irq_index_window.sv
module irq_index_window
    import irw_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter int         ID_W     = 4,
    parameter logic [7:0] VERSION  = 8'h20,
    localparam int        IDX_W    = $clog2(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [7:0]       req_addr,
    input  logic [2:0]       req_size,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    input  logic             stat_valid,
    input  logic [IDX_W-1:0] stat_idx,
    input  logic             stat_dlv,
    input  logic             stat_rirr,
    output logic             svc_valid,
    output logic [IDX_W-1:0] svc_idx,
    output logic             eoi_valid,
    output logic [7:0]       eoi_vector
);

    localparam bit         EOI_EN   = (VERSION == 8'h20);
    localparam logic [7:0] VER_CODE = EOI_EN ? 8'h20 : 8'h11;

    irw_req_t          req_in;
    irw_req_t          cap;
    logic [7:0]        sel_q;
    logic [ID_W-1:0]   id_q;
    irw_op_e           op;
    irw_win_e          win;
    logic [IDX_W-1:0]  ent_num;
    logic              ent_hi;
    logic [31:0]       tbl_data;
    logic [31:0]       win_data;
    logic              tbl_wr_en;

    assign req_in = '{wr: req_write, addr: req_addr, size: req_size, wdata: req_wdata};

    irw_ctrl #(
        .IDX_W  (IDX_W),
        .ID_W   (ID_W),
        .EOI_EN (EOI_EN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_in     (req_in),
        .cap        (cap),
        .sel_q      (sel_q),
        .id_q       (id_q),
        .op         (op),
        .win        (win),
        .ent_num    (ent_num),
        .win_data   (win_data),
        .tbl_wr_en  (tbl_wr_en),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .svc_valid  (svc_valid),
        .svc_idx    (svc_idx),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector)
    );

    irw_decode #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .cap_addr (cap.addr),
        .cap_size (cap.size),
        .sel_q    (sel_q),
        .op       (op),
        .win      (win),
        .ent_num  (ent_num),
        .ent_hi   (ent_hi)
    );

    irw_table #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr_en),
        .wr_num     (ent_num),
        .wr_hi      (ent_hi),
        .wr_data    (cap.wdata),
        .stat_valid (stat_valid),
        .stat_idx   (stat_idx),
        .stat_dlv   (stat_dlv),
        .stat_rirr  (stat_rirr),
        .rd_num     (ent_num),
        .rd_hi      (ent_hi),
        .rd_data    (tbl_data)
    );

    irw_readmux #(
        .NUM_PINS (NUM_PINS),
        .ID_W     (ID_W),
        .VER_CODE (VER_CODE)
    ) u_readmux (
        .win      (win),
        .id_q     (id_q),
        .tbl_data (tbl_data),
        .win_data (win_data)
    );

endmodule

// File: rtl/irw_checker.sv
module irw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [7:0] req_addr,
    input logic [2:0] req_size,
    input logic       rsp_valid,
    input logic       svc_valid,
    input logic       eoi_valid
);

    // R2: response two edges after acceptance
    a_r2_rsp_two_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid);

    // R2: response lasts a single cycle
    a_r2_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2: no acceptance while responding
    a_r2_busy_while_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10: service request only from a full-size window write
    a_r10_svc_from_window_write: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> rsp_valid && $past(req_write, 2) && $past(req_addr, 2) == 8'h10
                      && $past(req_size, 2) == 3'd4);

    // R11: end-of-interrupt only from a full-size write to its offset
    a_r11_eoi_from_eoi_write: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> rsp_valid && $past(req_write, 2) && $past(req_addr, 2) == 8'h40
                      && $past(req_size, 2) == 3'd4);

endmodule

bind irq_index_window irw_checker u_irw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .svc_valid (svc_valid),
    .eoi_valid (eoi_valid)
);

// File: tb/test_irq_index_window.sv
module test_irq_index_window;

    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        stat_valid = 1'b0;
    logic [4:0]  stat_idx = '0;
    logic        stat_dlv = 1'b0;
    logic        stat_rirr = 1'b0;

    logic        req_ready, rsp_valid, svc_valid, eoi_valid;
    logic [31:0] rsp_rdata;
    logic [4:0]  svc_idx;
    logic [7:0]  eoi_vector;

    logic        b_ready, b_rsp_valid, b_svc_valid, b_eoi_valid;
    logic [31:0] b_rsp_rdata;
    logic [4:0]  b_svc_idx;
    logic [7:0]  b_eoi_vector;

    int checks = 0;
    int errors = 0;

    logic [31:0] g_rdata, gb_rdata;
    logic        g_rsp, g_pre, g_svc, g_eoi, gb_eoi;
    logic [4:0]  g_svc_idx;
    logic [7:0]  g_eoi_vec;

    logic [31:0] exp_lo [NP];
    logic [31:0] exp_hi [NP];

    always #5 clk = ~clk;

    irq_index_window #(.NUM_PINS(NP), .VERSION(8'h20)) i_irq_index_window (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .stat_valid(stat_valid), .stat_idx(stat_idx), .stat_dlv(stat_dlv),
        .stat_rirr(stat_rirr), .svc_valid(svc_valid), .svc_idx(svc_idx),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector));

    irq_index_window #(.NUM_PINS(NP), .VERSION(8'h11)) i_irq_index_window_v11 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(b_rsp_valid), .rsp_rdata(b_rsp_rdata),
        .stat_valid(stat_valid), .stat_idx(stat_idx), .stat_dlv(stat_dlv),
        .stat_rirr(stat_rirr), .svc_valid(b_svc_valid), .svc_idx(b_svc_idx),
        .eoi_valid(b_eoi_valid), .eoi_vector(b_eoi_vector));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One bus transaction; results are due after the second edge past acceptance.
    task automatic acc(input logic wr, input logic [7:0] addr, input logic [2:0] size,
                       input logic [31:0] wd);
        @(negedge clk);
        chk("R2 ready in idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        g_pre = rsp_valid;
        @(posedge clk);
        @(negedge clk);
        g_rsp = rsp_valid; g_rdata = rsp_rdata; gb_rdata = b_rsp_rdata;
        g_svc = svc_valid; g_svc_idx = svc_idx;
        g_eoi = eoi_valid; g_eoi_vec = eoi_vector; gb_eoi = b_eoi_valid;
        chk("R2 no early response", 32'(g_pre), 32'd0);
        chk("R2 response due", 32'(g_rsp), 32'd1);
        if (wr) chk("R2 write response data", g_rdata, 32'd0);
        @(posedge clk);
    endtask

    task automatic sel_rd(input logic [7:0] s);
        acc(1'b1, 8'h00, 3'd1, 32'(s));
        acc(1'b0, 8'h10, 3'd4, 32'd0);
    endtask

    task automatic sel_wr(input logic [7:0] s, input logic [31:0] d);
        acc(1'b1, 8'h00, 3'd4, 32'(s));
        acc(1'b1, 8'h10, 3'd4, d);
    endtask

    task automatic stat(input int idx, input logic dlv, input logic rirr);
        @(negedge clk);
        stat_valid = 1'b1; stat_idx = 5'(idx); stat_dlv = dlv; stat_rirr = rirr;
        @(posedge clk);
        @(negedge clk);
        stat_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        acc(1'b0, 8'h00, 3'd4, 32'd0);
        chk("R1 selector reset", g_rdata, 32'd0);
        sel_rd(8'h00);
        chk("R1 id reset", g_rdata, 32'd0);
        for (int n = 0; n < NP; n++) begin
            exp_lo[n] = 32'h0001_0000;
            exp_hi[n] = 32'h0;
            sel_rd(8'(8'h10 + 2 * n));
            chk("R1 entry low reset", g_rdata, exp_lo[n]);
            sel_rd(8'(8'h11 + 2 * n));
            chk("R1 entry high reset", g_rdata, exp_hi[n]);
        end

        // R6: version word and ignored writes
        sel_rd(8'h01);
        chk("R6 version v20", g_rdata, 32'h0017_0020);
        chk("R6 version v11", gb_rdata, 32'h0017_0011);
        sel_wr(8'h01, 32'hFFFF_FFFF);
        sel_rd(8'h01);
        chk("R6 version write ignored", g_rdata, 32'h0017_0020);

        // R5: identification and arbitration mirror
        sel_wr(8'h00, 32'hFFFF_FFFF);
        sel_rd(8'h00);
        chk("R5 id readback", g_rdata, 32'h0F00_0000);
        sel_wr(8'h02, 32'h0000_0000);
        sel_rd(8'h02);
        chk("R5 arb mirrors id", g_rdata, 32'h0F00_0000);
        sel_wr(8'h00, 32'h5A00_0000);
        sel_rd(8'h02);
        chk("R5 arb follows id", g_rdata, 32'h0A00_0000);

        // R8: status port sets both read-only bits
        for (int n = 0; n < NP; n++) stat(n, 1'b1, 1'b1);
        sel_rd(8'h10 + 8'd6);
        chk("R8 status bits set", g_rdata, 32'h0001_5000);

        // R7/R8/R9/R10: write every entry half and read it back
        for (int n = 0; n < NP; n++) begin
            logic [31:0] wl, wh;
            wl = 32'h0000_5000 | 32'(8'h20 + n) | (32'(n % 8) << 8)
               | ((n % 2 == 1) ? 32'h0000_8000 : 32'h0) | ((n % 3 == 0) ? 32'h0001_0000 : 32'h0);
            wh = (32'(n * 7 + 1) << 24) | (32'h0000_C0DE ^ 32'(n));
            sel_wr(8'(8'h10 + 2 * n), wl);
            chk("R10 svc on low write", 32'(g_svc), 32'd1);
            chk("R10 svc index", 32'(g_svc_idx), 32'(n));
            exp_lo[n] = (wl & ~32'h0000_5000) | 32'h0000_1000
                      | ((n % 2 == 1) ? 32'h0000_4000 : 32'h0);
            sel_wr(8'(8'h11 + 2 * n), wh);
            chk("R10 svc on high write", 32'(g_svc), 32'd1);
            exp_hi[n] = wh;
        end
        for (int n = 0; n < NP; n++) begin
            sel_rd(8'(8'h10 + 2 * n));
            chk("R8 R9 entry low readback", g_rdata, exp_lo[n]);
            sel_rd(8'(8'h11 + 2 * n));
            chk("R7 entry high readback", g_rdata, exp_hi[n]);
        end

        // R9: pending bit set on an edge entry is cleared by a high-half write
        stat(0, 1'b1, 1'b1);
        sel_rd(8'h10);
        chk("R8 edge entry status", g_rdata, exp_lo[0] | 32'h0000_4000);
        sel_wr(8'h11, 32'h1234_5678);
        sel_rd(8'h10);
        chk("R9 edge clears pending", g_rdata, exp_lo[0]);

        // R9: level entry switched to edge
        sel_wr(8'h13, 32'h0);
        sel_wr(8'h12, exp_lo[1] & ~32'h0000_8000);
        sel_rd(8'h12);
        chk("R9 level to edge", g_rdata, exp_lo[1] & ~32'h0000_C000);

        // R4: short window accesses
        for (int sz = 1; sz < 4; sz++) begin
            acc(1'b1, 8'h00, 3'd4, 32'h0000_0016);
            acc(1'b1, 8'h10, 3'(sz), 32'hDEAD_BEEF);
            chk("R4 short write no svc", 32'(g_svc), 32'd0);
            acc(1'b0, 8'h10, 3'(sz), 32'd0);
            chk("R4 short read zero", g_rdata, 32'd0);
        end
        sel_rd(8'h16);
        chk("R4 entry unchanged", g_rdata, exp_lo[3]);

        // R7: selectors outside the entries
        for (int s = 3; s < 256; s++) begin
            if (s >= 16 && s < 16 + 2 * NP) continue;
            sel_rd(8'(s));
            chk("R7 unmapped selector reads zero", g_rdata, 32'd0);
        end
        sel_wr(8'h40, 32'hFFFF_FFFF);
        chk("R7 out-of-range write no svc", 32'(g_svc), 32'd0);
        sel_rd(8'h3F);
        chk("R7 last entry untouched", g_rdata, exp_hi[NP - 1]);

        // R3: selector readback with narrow sizes
        acc(1'b1, 8'h00, 3'd1, 32'hFFFF_FFAB);
        acc(1'b0, 8'h00, 3'd2, 32'd0);
        chk("R3 selector readback", g_rdata, 32'h0000_00AB);

        // R12: other offsets
        acc(1'b0, 8'h04, 3'd4, 32'd0);
        chk("R12 offset 04 reads zero", g_rdata, 32'd0);
        acc(1'b1, 8'h20, 3'd4, 32'h0000_0010);
        chk("R12 write no svc", 32'(g_svc), 32'd0);
        acc(1'b0, 8'hFF, 3'd4, 32'd0);
        chk("R12 offset FF reads zero", g_rdata, 32'd0);
        acc(1'b0, 8'h00, 3'd4, 32'd0);
        chk("R12 selector unchanged", g_rdata, 32'h0000_00AB);

        // R11: end of interrupt
        acc(1'b1, 8'h40, 3'd4, 32'h1234_5677);
        chk("R11 eoi pulse v20", 32'(g_eoi), 32'd1);
        chk("R11 eoi vector", 32'(g_eoi_vec), 32'h77);
        chk("R11 no eoi v11", 32'(gb_eoi), 32'd0);
        acc(1'b1, 8'h40, 3'd2, 32'h0000_0033);
        chk("R4 R11 short eoi ignored", 32'(g_eoi), 32'd0);
        acc(1'b0, 8'h40, 3'd4, 32'd0);
        chk("R11 eoi read zero", g_rdata, 32'd0);
        chk("R11 eoi read no pulse", 32'(g_eoi), 32'd0);

        summary();
    end

endmodule